// File: doc/BRIEF.md
# Alarm-Capable Real-Time Counter

This peripheral keeps time for a chip from a slow 32768 Hz clock-enable strobe. A programmable divider turns that strobe into a slow tick. Each tick advances a free-running 32-bit counter. Software can read the counter or overwrite it over a simple 32-bit register bus. A plain scratch register is also provided, in which software records how many times the counter has wrapped. The hardware never changes that register.

Two alarm registers are compared against the counter. When a tick brings the counter onto an alarm value, a sticky event flag sets. Each tick also sets a tick event flag. All three flags live in one status register next to their enable bits. An event flag is cleared by writing 1 to its bit. A single level interrupt output is raised while any enabled event is pending.

The bus is a single-cycle register port. A write takes effect at the clock edge where `bus_sel` and `bus_we` are both high. Read data is combinational from `bus_addr` while `bus_sel` is high and `bus_we` is low. There is no back-pressure, so every access completes in the cycle it is presented. The counter advances only while the clock-source register holds 3.

Top module: `rtc_alarm_counter`

## Requirements
- R1: After reset the counter, both alarm registers, the status register, the clock-source register and the scratch register read 0, the divider register reads 1023, and `irq` is low.
- R2: The scratch register (offset 0x40) and the alarm registers (alarm A at 0x04, alarm B at 0x18) read back the last 32-bit value written, with no other effect.
- R3: With the divider register (0x0C) holding N, one counter tick occurs every 2*(N+1) cycles in which `ce_32k` is high. Writing the divider register restarts the divider's count from the new value.
- R4: The counter (0x00) and the divider hold still unless the clock-source register (0x1C) holds exactly 3.
- R5: A tick advances the counter by one, and the counter wraps from 0xFFFFFFFF to 0.
- R6: A write to the counter loads the written value at that clock edge. If a tick falls in the same cycle, the write wins, and the tick neither increments the counter nor sets any event.
- R7: An alarm event sets only when a tick moves the counter onto that alarm's value. Alarm A uses status bit 0 and alarm B uses status bit 4. Loading the counter by a write never sets an alarm event.
- R8: In the status register (0x08), event bits 0, 1 and 4 are cleared by writing 1 to them and are not changed by writing 0. Enable bits 2 (alarm A), 3 (tick) and 6 (alarm B) are plain read/write bits. All other bits read 0.
- R9: Status bit 1 (tick event) sets on every tick that advances the counter.
- R10: `irq` is high exactly when (bit0 and bit2) or (bit1 and bit3) or (bit4 and bit6).
- R11: Any offset not listed above, including 0x14, reads 0. A write to such an offset has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_32k | input | 1 | One-cycle strobe at the 32768 Hz reference rate |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The bench counts `ce_32k` strobes exactly and checks the tick period for two divider settings. A divider that is off by one, or that fails to restart when written, would leave the counter one step wrong.

It places a counter write on the very cycle of a tick, with an alarm armed one value ahead. A design that lets the tick win, or that raises events from an overridden tick, would show the wrong count or a stray event.

Writes of 0 to event bits, writes that land the counter directly on an alarm value, and the wrap from all-ones are each checked. These catch level-sensitive alarms, read-modify-write clearing and a saturating counter.

// File: rtl/rtcc_pkg.sv
package rtcc_pkg;
  localparam logic [7:0] OFS_COUNT  = 8'h00;
  localparam logic [7:0] OFS_ALARMA = 8'h04;
  localparam logic [7:0] OFS_STATUS = 8'h08;
  localparam logic [7:0] OFS_DIV    = 8'h0C;
  localparam logic [7:0] OFS_ALARMB = 8'h18;
  localparam logic [7:0] OFS_CLKSRC = 8'h1C;
  localparam logic [7:0] OFS_SCRATCH = 8'h40;

  // status bit positions
  localparam int ST_EV_A   = 0;
  localparam int ST_EV_TK  = 1;
  localparam int ST_EN_A   = 2;
  localparam int ST_EN_TK  = 3;
  localparam int ST_EV_B   = 4;
  localparam int ST_EN_B   = 6;

  localparam logic [31:0] CLKSRC_RUN = 32'h3;
endpackage

// File: rtl/rtcc_divider.sv
module rtcc_divider #(
  parameter int DATA_W  = 32,
  parameter int RST_DIV = 1023
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              ce,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  output logic [DATA_W-1:0] div_val,
  output logic              tick
);
  logic [DATA_W-1:0] div_q;
  logic [DATA_W-1:0] cnt_q;
  logic              phase_q;
  logic              wrap;

  assign div_val = div_q;
  assign wrap    = run && ce && !load && (cnt_q == '0);
  assign tick    = wrap && phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q   <= DATA_W'(RST_DIV);
      cnt_q   <= DATA_W'(RST_DIV);
      phase_q <= 1'b0;
    end else if (load) begin
      div_q   <= load_val;
      cnt_q   <= load_val;
      phase_q <= 1'b0;
    end else if (run && ce) begin
      if (wrap) begin
        cnt_q   <= div_q;
        phase_q <= !phase_q;
      end else begin
        cnt_q <= cnt_q - DATA_W'(1);
      end
    end
  end

  AST_DIV_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= div_q); // R3
  AST_DIV_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(cnt_q)); // R4
  AST_TICK_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (ce && run)); // R3
endmodule

// File: rtl/rtcc_counter.sv
module rtcc_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_val,
  output logic [DATA_W-1:0] value,
  output logic              step,
  output logic [DATA_W-1:0] next_val
);
  assign step     = tick && !wr_en;
  assign next_val = value + DATA_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)     value <= '0;
    else if (wr_en) value <= wr_val;
    else if (tick)  value <= next_val;
  end

  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (value == $past(wr_val))); // R6
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (value == $past(value) + DATA_W'(1))); // R5
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable(value)); // R4
endmodule

// File: rtl/rtcc_evflag.sv
module rtcc_evflag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag); // R8
  AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !set) |=> !flag); // R7
endmodule

// File: rtl/rtc_alarm_counter.sv
module rtc_alarm_counter #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter int RST_DIV = 1023
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_32k,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  import rtcc_pkg::*;

  localparam int NUM_ALARM = 2;

  logic              wr;
  logic              st_wr;
  logic [DATA_W-1:0] alarm_q [NUM_ALARM];
  logic [DATA_W-1:0] clksrc_q;
  logic [DATA_W-1:0] scratch_q;
  logic [DATA_W-1:0] div_val;
  logic [DATA_W-1:0] cnt_val;
  logic [DATA_W-1:0] cnt_next;
  logic [DATA_W-1:0] status;
  logic [NUM_ALARM-1:0] al_ev;
  logic [NUM_ALARM-1:0] al_en;
  logic              tk_ev;
  logic              tk_en_q;
  logic              running;
  logic              tick;
  logic              step;
  logic              cnt_wr;

  assign wr      = bus_sel && bus_we;
  assign st_wr   = wr && (bus_addr == ADDR_W'(OFS_STATUS));
  assign cnt_wr  = wr && (bus_addr == ADDR_W'(OFS_COUNT));
  assign running = (clksrc_q == DATA_W'(CLKSRC_RUN));

  rtcc_divider #(.DATA_W(DATA_W), .RST_DIV(RST_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .run(running), .ce(ce_32k),
    .load(wr && (bus_addr == ADDR_W'(OFS_DIV))), .load_val(bus_wdata),
    .div_val(div_val), .tick(tick)
  );

  rtcc_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(cnt_wr),
    .wr_val(bus_wdata), .value(cnt_val), .step(step), .next_val(cnt_next)
  );

  for (genvar g = 0; g < NUM_ALARM; g++) begin : g_alarm
    localparam logic [7:0] OFS = (g == 0) ? OFS_ALARMA : OFS_ALARMB;
    localparam int EVB = (g == 0) ? ST_EV_A : ST_EV_B;
    localparam int ENB = (g == 0) ? ST_EN_A : ST_EN_B;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        alarm_q[g] <= '0;
        al_en[g]   <= 1'b0;
      end else begin
        if (wr && (bus_addr == ADDR_W'(OFS))) alarm_q[g] <= bus_wdata;
        if (st_wr) al_en[g] <= bus_wdata[ENB];
      end
    end

    rtcc_evflag u_ev (
      .clk(clk), .rst_n(rst_n),
      .set(step && (cnt_next == alarm_q[g])),
      .clr(st_wr && bus_wdata[EVB]),
      .flag(al_ev[g])
    );
  end

  rtcc_evflag u_tick_ev (
    .clk(clk), .rst_n(rst_n), .set(step),
    .clr(st_wr && bus_wdata[ST_EV_TK]), .flag(tk_ev)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clksrc_q  <= '0;
      scratch_q <= '0;
      tk_en_q   <= 1'b0;
    end else begin
      if (wr && (bus_addr == ADDR_W'(OFS_CLKSRC)))  clksrc_q  <= bus_wdata;
      if (wr && (bus_addr == ADDR_W'(OFS_SCRATCH))) scratch_q <= bus_wdata;
      if (st_wr) tk_en_q <= bus_wdata[ST_EN_TK];
    end
  end

  always_comb begin
    status           = '0;
    status[ST_EV_A]  = al_ev[0];
    status[ST_EV_TK] = tk_ev;
    status[ST_EN_A]  = al_en[0];
    status[ST_EN_TK] = tk_en_q;
    status[ST_EV_B]  = al_ev[1];
    status[ST_EN_B]  = al_en[1];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      case (bus_addr)
        ADDR_W'(OFS_COUNT):   bus_rdata = cnt_val;
        ADDR_W'(OFS_ALARMA):  bus_rdata = alarm_q[0];
        ADDR_W'(OFS_STATUS):  bus_rdata = status;
        ADDR_W'(OFS_DIV):     bus_rdata = div_val;
        ADDR_W'(OFS_ALARMB):  bus_rdata = alarm_q[1];
        ADDR_W'(OFS_CLKSRC):  bus_rdata = clksrc_q;
        ADDR_W'(OFS_SCRATCH): bus_rdata = scratch_q;
        default:              bus_rdata = '0;
      endcase
    end
  end

  assign irq = (al_ev[0] && al_en[0]) || (tk_ev && tk_en_q) || (al_ev[1] && al_en[1]);

  AST_STALLED_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !cnt_wr) |=> $stable(cnt_val)); // R4
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (al_ev != '0 || tk_ev)); // R10
  AST_NO_EVENT_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && !tk_ev) |=> !tk_ev); // R6
endmodule

// File: tb/test_rtc_alarm_counter.sv
`timescale 1ns/1ps
module test_rtc_alarm_counter;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        ce_32k = 0;
  logic        bus_sel = 0;
  logic        bus_we = 0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  rtc_alarm_counter i_rtc_alarm_counter (
    .clk(clk), .rst_n(rst_n), .ce_32k(ce_32k), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  // monitor: compares each read against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && bus_sel && !bus_we) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL %s: read with no expectation, actual %h expected none", "scoreboard", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          n_bad++;
          $display("FAIL %s: addr %h actual %h expected %h", t, bus_addr, bus_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    exp_q.push_back(e); tag_q.push_back(t);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    @(posedge clk); #1;
    bus_sel = 0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    n_chk++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s: irq actual %b expected %b", t, irq, e);
    end
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; ce_32k = 1;
    end
    @(posedge clk); #1; ce_32k = 0;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    rd(8'h00, 32'h0, "R1 counter");
    rd(8'h08, 32'h0, "R1 status");
    rd(8'h0C, 32'd1023, "R1 divider");
    rd(8'h1C, 32'h0, "R1 clksrc");
    rd(8'h40, 32'h0, "R1 scratch");
    rd(8'h04, 32'h0, "R1 alarmA");
    chk_irq(1'b0, "R1 irq");

    // R2 storage registers
    wr(8'h40, 32'hA5A5_0003);
    rd(8'h40, 32'hA5A5_0003, "R2 scratch");
    wr(8'h04, 32'h10);
    rd(8'h04, 32'h10, "R2 alarmA");
    wr(8'h18, 32'h20);
    rd(8'h18, 32'h20, "R2 alarmB");

    // R11 unmapped
    wr(8'h14, 32'hFFFF);
    rd(8'h14, 32'h0, "R11 offset 0x14");
    rd(8'h24, 32'h0, "R11 offset 0x24");

    // R4 no advance unless source is 3
    wr(8'h1C, 32'h2);
    wr(8'h00, 32'd7);
    wr(8'h0C, 32'd1);
    pulses(20);
    rd(8'h00, 32'd7, "R4 counter stalled");
    rd(8'h1C, 32'h2, "R4 clksrc");

    // R3 tick rate, R9 tick event
    wr(8'h1C, 32'h3);
    pulses(16);
    rd(8'h00, 32'd11, "R3 N=1 four ticks");
    rd(8'h08, 32'h2, "R9 tick event");
    wr(8'h08, 32'h2);
    rd(8'h08, 32'h0, "R8 clear tick");
    wr(8'h0C, 32'd2);
    pulses(18);
    rd(8'h00, 32'd14, "R3 N=2 three ticks");
    wr(8'h08, 32'h0);
    rd(8'h08, 32'h2, "R8 zero leaves event");
    wr(8'h08, 32'h2);

    // R7/R10 alarm A
    wr(8'h0C, 32'd1);
    pulses(8);
    rd(8'h00, 32'h10, "R3 counter at alarm");
    rd(8'h08, 32'h3, "R7 alarmA event");
    chk_irq(1'b0, "R10 no enables");
    wr(8'h08, 32'h4);
    rd(8'h08, 32'h7, "R8 enable A");
    chk_irq(1'b1, "R10 alarmA");
    wr(8'h08, 32'h5);
    rd(8'h08, 32'h6, "R8 clear alarmA");
    chk_irq(1'b0, "R10 tick not enabled");
    wr(8'h08, 32'hC);
    rd(8'h08, 32'hE, "R8 enable tick");
    chk_irq(1'b1, "R10 tick");
    wr(8'h08, 32'hA);
    rd(8'h08, 32'h8, "R8 clear tick drop A");
    chk_irq(1'b0, "R10 cleared");

    // R7 alarm B
    pulses(64);
    rd(8'h00, 32'h20, "R5 sixteen ticks");
    rd(8'h08, 32'h1A, "R7 alarmB event");
    chk_irq(1'b1, "R10 tick irq");
    wr(8'h08, 32'h42);
    rd(8'h08, 32'h50, "R8 enable B");
    chk_irq(1'b1, "R10 alarmB");
    wr(8'h08, 32'h50);
    rd(8'h08, 32'h40, "R8 clear alarmB");
    chk_irq(1'b0, "R10 alarmB cleared");

    // R5 wrap
    wr(8'h00, 32'hFFFF_FFFF);
    pulses(4);
    rd(8'h00, 32'h0, "R5 wrap");
    rd(8'h08, 32'h42, "R9 tick on wrap");
    wr(8'h08, 32'h02);
    rd(8'h08, 32'h0, "R8 status clear");

    // R6 write beats tick
    wr(8'h00, 32'h1233);
    wr(8'h0C, 32'd1);
    pulses(3);
    rd(8'h00, 32'h1233, "R3 no tick yet");
    wr(8'h04, 32'h1234);
    @(posedge clk); #1;
    ce_32k = 1; bus_sel = 1; bus_we = 1; bus_addr = 8'h00; bus_wdata = 32'h9000;
    @(posedge clk); #1;
    ce_32k = 0; bus_sel = 0; bus_we = 0;
    rd(8'h00, 32'h9000, "R6 write wins");
    rd(8'h08, 32'h0, "R6 overridden tick no events");

    // R7 direct load onto alarm value
    wr(8'h04, 32'h5555);
    wr(8'h00, 32'h5555);
    rd(8'h08, 32'h0, "R7 load does not fire alarm");

    repeat (3) @(posedge clk);
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule